// File: doc/BRIEF.md
# Majority-Logic (8,2) Double-Error-Correcting Codec

This block protects two data bits by spreading them over an 8-bit group code word and recovers them even when any two of the eight received bits are flipped. The encoder side is purely combinational. It places the two data bits at word positions 5 and 8 and derives the six check positions from them.

The decoder side does not look up a syndrome. For each data bit it forms five check sums. Each check sum is either a single received bit or the XOR of two received bits. The sets are chosen so that every other received bit feeds at most one sum for that data bit. A 5-input majority vote then picks the value. Two wrong bits can spoil at most two of the five sums, so the three intact sums outvote them.

Alongside the two data bits, the decoder returns three more results. It re-encodes the decoded data bits into a corrected word. It XORs that word with the received word to give the error vector. It also counts the set bits of that vector to give the error weight. The results are registered with one cycle of latency, and a single valid flag travels with them.

Top module: `maj82_codec`

## Requirements
- R1: `enc_word` is the combinational code word for `enc_info`. Bit index i-1 of the word holds position i. `enc_info[0]` is the first data bit (d0) and `enc_info[1]` is the second data bit (d1). Positions 5 and 8 hold d0 and d1. Positions 3 and 4 hold d0. Positions 6 and 7 hold d1. Positions 1 and 2 hold d0 XOR d1.
- R2: `out_valid` is high exactly in the cycle after a clock edge at which `in_valid` was high. A synchronous `rst` clears `out_valid` and all result registers to zero.
- R3: Data bit d0 is the majority (at least 3 of 5) of these check sums over the received positions: p6^p1, p7^p2, p3, p4 and p5. Data bit d1 is the majority of p3^p1, p4^p2, p6, p7 and p8. The decoded pair appears on `out_info` with the same bit order as `enc_info`.
- R4: For every code word and every error pattern of weight 0, 1 or 2, `out_info` equals the original data bits.
- R5: `out_fixed` equals the R1 encoding of the decoded `out_info`.
- R6: `out_errvec` equals `out_fixed` XOR the received word. `out_errwt` is the number of ones in `out_errvec`.
- R7: While `in_valid` is low, `out_info`, `out_fixed`, `out_errvec` and `out_errwt` keep their values, whatever is on `rx_word`.
- R8: A received word that is already a code word is returned unchanged on `out_fixed`, and `out_errwt` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| enc_info | input | 2 | Data bits to encode (bit 0 = d0, bit 1 = d1) |
| enc_word | output | 8 | Code word for `enc_info`, bit i-1 = position i |
| in_valid | input | 1 | `rx_word` holds a word to decode |
| rx_word | input | 8 | Received word, possibly corrupted |
| out_valid | output | 1 | Results below are fresh this cycle |
| out_info | output | 2 | Decoded data bits |
| out_fixed | output | 8 | Corrected code word |
| out_errvec | output | 8 | Positions found to be in error |
| out_errwt | output | 4 | Number of positions in error |

## Verification
The bench sends all four code words through every weight-0, weight-1 and weight-2 error pattern, 37 patterns per word. Patterns that hit both copies feeding one check sum are among them. A decoder with a check sum wired to the wrong position, or a vote threshold of 2 or 4, returns a wrong data bit for some of these double errors. Each case also compares the error vector and weight against the injected pattern. A corrected word built from the received bits instead of the decoded ones would show up there as a nonzero or wrong vector. Separate scenarios drive new words on `rx_word` while `in_valid` is low, to catch registers that load regardless of the flag. They also check that the valid flag drops one cycle after a single-cycle request.

// File: rtl/maj82_codec.sv
module maj82_codec (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] enc_info,
  output logic [7:0] enc_word,
  input  logic       in_valid,
  input  logic [7:0] rx_word,
  output logic       out_valid,
  output logic [1:0] out_info,
  output logic [7:0] out_fixed,
  output logic [7:0] out_errvec,
  output logic [3:0] out_errwt
);

  function automatic logic [7:0] build_word(logic d0, logic d1);
    return {d1, d1, d1, d0, d0, d0, d0 ^ d1, d0 ^ d1};
  endfunction

  function automatic logic vote5(logic [4:0] v);
    logic [2:0] n;
    n = 3'd0;
    for (int i = 0; i < 5; i++) n = n + {2'b00, v[i]};
    return n >= 3'd3;
  endfunction

  function automatic logic [3:0] ones8(logic [7:0] v);
    logic [3:0] n;
    n = 4'd0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

  assign enc_word = build_word(enc_info[0], enc_info[1]);

  logic [4:0] chk_d0, chk_d1;
  logic [1:0] dec_info;
  logic [7:0] dec_word, dec_err;

  assign chk_d0 = {rx_word[4], rx_word[3], rx_word[2],
                   rx_word[6] ^ rx_word[1], rx_word[5] ^ rx_word[0]};
  assign chk_d1 = {rx_word[7], rx_word[6], rx_word[5],
                   rx_word[3] ^ rx_word[1], rx_word[2] ^ rx_word[0]};

  assign dec_info = {vote5(chk_d1), vote5(chk_d0)};
  assign dec_word = build_word(dec_info[0], dec_info[1]);
  assign dec_err  = dec_word ^ rx_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_info   <= '0;
      out_fixed  <= '0;
      out_errvec <= '0;
      out_errwt  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_info   <= dec_info;
        out_fixed  <= dec_word;
        out_errvec <= dec_err;
        out_errwt  <= ones8(dec_err);
      end
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_reset_clear_r2: assert property (@(posedge clk)
    rst |=> (!out_valid && out_errwt == 4'd0));
  p_weight_match_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (4'($countones(out_errvec)) == out_errwt));
  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(out_info) && $stable(out_fixed) && $stable(out_errvec)));
  p_clean_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && rx_word == build_word(rx_word[4], rx_word[7]))
      |=> (out_fixed == $past(rx_word) && out_errwt == 4'd0));

endmodule

// File: tb/maj82_codec_bench.sv
`timescale 1ns/1ps
module maj82_codec_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] enc_info;
  logic [7:0] enc_word;
  logic       in_valid;
  logic [7:0] rx_word;
  logic       out_valid;
  logic [1:0] out_info;
  logic [7:0] out_fixed, out_errvec;
  logic [3:0] out_errwt;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  maj82_codec u_maj82_codec (
    .clk(clk), .rst(rst), .enc_info(enc_info), .enc_word(enc_word),
    .in_valid(in_valid), .rx_word(rx_word), .out_valid(out_valid),
    .out_info(out_info), .out_fixed(out_fixed), .out_errvec(out_errvec),
    .out_errwt(out_errwt)
  );

  function automatic logic [7:0] ref_word(logic [1:0] d);
    logic [7:0] w;
    w[0] = d[0] ^ d[1]; w[1] = d[0] ^ d[1];
    w[2] = d[0]; w[3] = d[0]; w[4] = d[0];
    w[5] = d[1]; w[6] = d[1]; w[7] = d[1];
    return w;
  endfunction

  function automatic int pop8(logic [7:0] v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += v[i];
    return n;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] w);
    @(negedge clk);
    rx_word = w;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b0; rx_word = 8'hFF; enc_info = 2'b00;
    repeat (3) @(negedge clk);
    check("R2 reset valid", 32'(out_valid), 0);
    check("R2 reset errwt", 32'(out_errwt), 0);
    check("R2 reset fixed", 32'(out_fixed), 0);
    rst = 1'b0;
  endtask

  task automatic t_encode;
    for (int d = 0; d < 4; d++) begin
      @(negedge clk);
      enc_info = 2'(d);
      #1;
      check($sformatf("R1 encode d=%0d", d), 32'(enc_word), 32'(ref_word(2'(d))));
    end
  endtask

  task automatic t_one(input logic [1:0] d, input logic [7:0] pat);
    send(ref_word(d) ^ pat);
    check($sformatf("R2 valid pat=%h", pat), 32'(out_valid), 1);
    check($sformatf("R3 R4 info d=%0d pat=%h", d, pat), 32'(out_info), 32'(d));
    check($sformatf("R5 fixed d=%0d pat=%h", d, pat), 32'(out_fixed), 32'(ref_word(d)));
    check($sformatf("R6 errvec d=%0d pat=%h", d, pat), 32'(out_errvec), 32'(pat));
    check($sformatf("R6 errwt d=%0d pat=%h", d, pat), 32'(out_errwt), 32'(pop8(pat)));
  endtask

  task automatic t_exhaustive;
    for (int d = 0; d < 4; d++) begin
      t_one(2'(d), 8'h00);
      for (int i = 0; i < 8; i++) begin
        t_one(2'(d), 8'(1 << i));
        for (int j = i + 1; j < 8; j++) t_one(2'(d), 8'((1 << i) | (1 << j)));
      end
    end
  endtask

  task automatic t_clean;
    send(ref_word(2'b10));
    check("R8 clean fixed", 32'(out_fixed), 32'(ref_word(2'b10)));
    check("R8 clean errwt", 32'(out_errwt), 0);
  endtask

  task automatic t_hold;
    send(ref_word(2'b01) ^ 8'h81);
    rx_word = ref_word(2'b10);
    repeat (3) @(negedge clk);
    check("R2 valid low after gap", 32'(out_valid), 0);
    check("R7 info held", 32'(out_info), 32'(2'b01));
    check("R7 errvec held", 32'(out_errvec), 32'h81);
    check("R7 fixed held", 32'(out_fixed), 32'(ref_word(2'b01)));
  endtask

  initial begin
    t_reset;
    t_encode;
    t_exhaustive;
    t_clean;
    t_hold;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++;
    bad++;
    $display("FAIL R2 watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule